// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block sits next to a memory and keeps track of address reservations made by load-locked reads. The reservations belong to a fixed set of requesting contexts, where a context is one hardware thread. The memory array, its latency and its data path are outside the block. The block sees a stream of reads and a stream of writes, each tagged with a context number and a physical address. It returns a write-enable for the memory and, for conditional stores, a pass or fail result.

The table holds one slot per context, indexed by context number. A slot holds a valid bit and the granule part of an address, meaning the address with its low `GRAN_LG` bits dropped. A locked read fills or replaces the slot of its own context. Every accepted write compares its granule against all valid slots and clears each slot that matches. A conditional store succeeds only when the writing context's own slot matched. Both request streams use valid/ready. The block never applies back-pressure: each `*_ready` is low while reset is asserted and from the first clock edge after reset is released it stays high, so a request counts as accepted whenever its valid is high and ready is high. The context-clear input and the three result outputs are plain pins with no handshake.

Top module: `lrsc_monitor`

## Requirements
- R1: A synchronous active-low reset clears every reservation and drives `mem_we`, `sc_valid` and `sc_result` to 0. A conditional store issued right after reset fails.
- R2: A locked read (`rd_locked`=1) from context C records a reservation for C. A later conditional store from C to the same granule gives `mem_we`=1, `sc_valid`=1 and `sc_result`=1.
- R3: A second locked read from a context that already holds a reservation replaces its address. A conditional store to the old granule then fails, and one to the new granule succeeds.
- R4: Addresses are compared on bits `[ADDR_W-1:GRAN_LG]` only, so two addresses that differ only in their low `GRAN_LG` bits (16-byte granule by default) match.
- R5: Plain reads and locked reads never remove any existing reservation, whether it belongs to their own context or to another.
- R6: A plain write (`wr_cond`=0) always gives `mem_we`=1 and `sc_valid`=0, whatever the table holds.
- R7: A conditional store fails when its own context holds no matching reservation, even if another context holds one for the same granule. A failed store gives `mem_we`=0, `sc_valid`=1 and `sc_result`=0.
- R8: Every accepted write clears all reservations whose granule matches it, for every context. This holds for plain writes and for conditional stores, whether they succeed or fail.
- R9: The outputs are registered. They reflect the write accepted at clock edge N during the cycle after edge N, and they are 0 in a cycle after an edge with no accepted write.
- R10: `clr_valid` with `clr_ctx`=C removes only context C's reservation.
- R11: When a locked read and a write reach the same granule at the same edge, the write is resolved against the old table and its invalidation is applied first. The locked read's reservation is then recorded and survives. The same order holds for a clear together with a locked read from the cleared context.
- R12: `rd_ready` and `wr_ready` are 0 while reset is asserted and 1 from the first edge after reset is released onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read stream accepts (high outside reset) |
| rd_ctx | input | CTX_W | Context issuing the read |
| rd_addr | input | ADDR_W | Physical address of the read |
| rd_locked | input | 1 | Read is load-locked |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write stream accepts (high outside reset) |
| wr_ctx | input | CTX_W | Context issuing the write |
| wr_addr | input | ADDR_W | Physical address of the write |
| wr_cond | input | 1 | Write is a conditional store |
| clr_valid | input | 1 | Drop one context's reservation |
| clr_ctx | input | CTX_W | Context whose reservation is dropped |
| mem_we | output | 1 | Registered write-enable to the memory |
| sc_valid | output | 1 | Registered: a conditional store was resolved |
| sc_result | output | 1 | Registered: 1 on success, 0 on failure |

## Verification
On every cycle the checker tests the following. A plain write always enables memory, and a failed conditional store never does. A passing store always writes. Idle edges leave the outputs quiet. A locked read always leaves its slot valid, and a clear empties its slot unless a locked read to the same context coincides with it. The ready outputs stay high after reset. Only the bench's reference model can show which context's reservation survives a write. That covers granule aliasing, replacement of an old address, invalidation across several contexts, and the ordering when a write or clear meets a locked read at the same edge.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  // Resolved outcome of one write, before the output register.
  typedef struct packed {
    logic we;        // memory may be updated
    logic sc_valid;  // a conditional store was resolved
    logic sc_ok;     // the conditional store passed
  } lrsc_outcome_t;
endpackage

// File: rtl/lrsc_slot.sv
// One reservation slot, owned by a single context.
module lrsc_slot #(
  parameter int TAG_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             clr,
  input  logic             set,
  input  logic [TAG_W-1:0] set_tag,
  output logic             valid,
  output logic [TAG_W-1:0] tag,
  output logic             match
);
  assign match = valid && (tag == wr_tag);

  // Invalidation (write hit or clear) first, new reservation last.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
    end else if (set) begin
      valid <= 1'b1;
    end else if ((wr_fire && match) || clr) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (set) tag <= set_tag;
  end
endmodule

// File: rtl/lrsc_resolve.sv
// Decides the write outcome against the table as it stood before this edge.
module lrsc_resolve
  import lrsc_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2
) (
  input  logic               wr_fire,
  input  logic               wr_cond,
  input  logic [CTX_W-1:0]   wr_ctx,
  input  logic [NUM_CTX-1:0] match_vec,
  output lrsc_outcome_t      outcome
);
  logic own_hit;

  always_comb begin
    own_hit = 1'b0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (wr_ctx == CTX_W'(i)) own_hit = match_vec[i];
    end
  end

  always_comb begin
    outcome.we       = wr_fire && (!wr_cond || own_hit);
    outcome.sc_valid = wr_fire && wr_cond;
    outcome.sc_ok    = wr_fire && wr_cond && own_hit;
  end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int ADDR_W  = 32,
  parameter int GRAN_LG = 4,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int TAG_W  = ADDR_W - GRAN_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [CTX_W-1:0]  rd_ctx,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_locked,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [CTX_W-1:0]  wr_ctx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_cond,
  input  logic              clr_valid,
  input  logic [CTX_W-1:0]  clr_ctx,
  output logic              mem_we,
  output logic              sc_valid,
  output logic              sc_result
);
  logic               ready_q;
  logic               rd_fire, wr_fire, lr_fire;
  logic [TAG_W-1:0]   rd_tag, wr_tag;
  logic [NUM_CTX-1:0] resv_valid;
  logic [NUM_CTX-1:0] match_vec;
  logic [NUM_CTX-1:0] set_vec;
  logic [NUM_CTX-1:0] clr_vec;
  lrsc_outcome_t      outcome;

  // Never back-pressures; only held off during reset.
  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign rd_ready = ready_q;
  assign wr_ready = ready_q;

  assign rd_fire = rd_valid && ready_q;
  assign wr_fire = wr_valid && ready_q;
  assign lr_fire = rd_fire && rd_locked;

  // Granule masking: drop the low GRAN_LG bits.
  assign rd_tag = TAG_W'(rd_addr >> GRAN_LG);
  assign wr_tag = TAG_W'(wr_addr >> GRAN_LG);

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
    logic [TAG_W-1:0] slot_tag;
    assign set_vec[g] = lr_fire && (rd_ctx == CTX_W'(g));
    assign clr_vec[g] = clr_valid && (clr_ctx == CTX_W'(g));

    lrsc_slot #(.TAG_W(TAG_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_fire (wr_fire),
      .wr_tag  (wr_tag),
      .clr     (clr_vec[g]),
      .set     (set_vec[g]),
      .set_tag (rd_tag),
      .valid   (resv_valid[g]),
      .tag     (slot_tag),
      .match   (match_vec[g])
    );
  end

  lrsc_resolve #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_resolve (
    .wr_fire   (wr_fire),
    .wr_cond   (wr_cond),
    .wr_ctx    (wr_ctx),
    .match_vec (match_vec),
    .outcome   (outcome)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      sc_valid  <= 1'b0;
      sc_result <= 1'b0;
    end else begin
      mem_we    <= outcome.we;
      sc_valid  <= outcome.sc_valid;
      sc_result <= outcome.sc_ok;
    end
  end
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_valid,
  input logic               rd_ready,
  input logic               rd_locked,
  input logic [CTX_W-1:0]   rd_ctx,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic               wr_cond,
  input logic               clr_valid,
  input logic [CTX_W-1:0]   clr_ctx,
  input logic               mem_we,
  input logic               sc_valid,
  input logic               sc_result,
  input logic [NUM_CTX-1:0] resv_valid
);
  p_plain_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !wr_cond) |=> (mem_we && !sc_valid));

  p_fail_blocks_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && !sc_result) |-> !mem_we);

  p_pass_writes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && sc_result) |-> mem_we);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> (!mem_we && !sc_valid && !sc_result));

  p_lr_records_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_locked) |=> resv_valid[$past(rd_ctx)]);

  p_clear_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && !(rd_valid && rd_ready && rd_locked && rd_ctx == clr_ctx))
      |=> !resv_valid[$past(clr_ctx)]);

  p_ready_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rd_ready && wr_ready));
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_locked  (rd_locked),
  .rd_ctx     (rd_ctx),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_cond    (wr_cond),
  .clr_valid  (clr_valid),
  .clr_ctx    (clr_ctx),
  .mem_we     (mem_we),
  .sc_valid   (sc_valid),
  .sc_result  (sc_result),
  .resv_valid (resv_valid)
);

// File: tb/lrsc_monitor_bench.sv
`timescale 1ns/1ps
module lrsc_monitor_bench;
  localparam int NC = 4;
  localparam int AW = 32;
  localparam int GL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_valid = 0, rd_locked = 0, wr_valid = 0, wr_cond = 0, clr_valid = 0;
  logic [1:0]    rd_ctx = 0, wr_ctx = 0, clr_ctx = 0;
  logic [AW-1:0] rd_addr = 0, wr_addr = 0;
  logic          rd_ready, wr_ready, mem_we, sc_valid, sc_result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model: per-context reservation flag and granule.
  bit          mv [NC];
  int unsigned mg [NC];

  always #2 clk = ~clk;

  lrsc_monitor #(.NUM_CTX(NC), .ADDR_W(AW), .GRAN_LG(GL)) u_lrsc_monitor (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_ctx(rd_ctx), .rd_addr(rd_addr), .rd_locked(rd_locked),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_ctx(wr_ctx), .wr_addr(wr_addr), .wr_cond(wr_cond),
    .clr_valid(clr_valid), .clr_ctx(clr_ctx),
    .mem_we(mem_we), .sc_valid(sc_valid), .sc_result(sc_result)
  );

  task automatic compare(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {ready,we,sc_valid,sc_result} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive one cycle from the negedge, update the model, check after the edge.
  task automatic step(string tag, bit rv, bit rl, int rc, int unsigned ra,
                      bit wv, bit wc, int wcx, int unsigned wa, bit cv, int cc);
    int unsigned gw, gr;
    bit own, ok;
    logic [3:0] exp;
    rd_valid = rv; rd_locked = rl; rd_ctx = 2'(rc); rd_addr = ra;
    wr_valid = wv; wr_cond = wc; wr_ctx = 2'(wcx); wr_addr = wa;
    clr_valid = cv; clr_ctx = 2'(cc);
    gw  = wa >> GL;
    gr  = ra >> GL;
    own = mv[wcx] && (mg[wcx] == gw);
    ok  = !wc || own;
    exp = {1'b1, wv && ok, wv && wc, wv && wc && own};
    if (wv) for (int i = 0; i < NC; i++) if (mv[i] && mg[i] == gw) mv[i] = 0;
    if (cv) mv[cc] = 0;
    if (rv && rl) begin mv[rc] = 1; mg[rc] = gr; end
    @(posedge clk);
    @(negedge clk);
    compare(tag, {rd_ready && wr_ready, mem_we, sc_valid, sc_result}, exp);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic lr(string tag, int c, int unsigned a);
    step(tag, 1, 1, c, a, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic sc(string tag, int c, int unsigned a);
    step(tag, 0, 0, 0, 0, 1, 1, c, a, 0, 0);
  endtask
  task automatic pw(string tag, int c, int unsigned a);
    step(tag, 0, 0, 0, 0, 1, 0, c, a, 0, 0);
  endtask

  localparam int unsigned A = 32'h100;
  localparam int unsigned B = 32'h200;

  initial begin
    for (int i = 0; i < NC; i++) begin mv[i] = 0; mg[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state, ready low during reset
    compare("R1 reset", {rd_ready || wr_ready, mem_we, sc_valid, sc_result}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    idle("R12 ready after reset");
    sc("R1 SC after reset fails", 0, A);

    lr("R2 LR ctx0", 0, A);
    sc("R2 SC ctx0 passes", 0, A);
    lr("R4 LR ctx1", 1, A + 4);
    sc("R4 SC ctx1 same granule passes", 1, A + 12);

    lr("R3 LR ctx2 old", 2, A);
    lr("R3 LR ctx2 new", 2, B);
    sc("R3 SC old granule fails", 2, A);
    sc("R3 SC new granule passes", 2, B);

    lr("R5 LR ctx0", 0, A);
    step("R5 plain read ctx1", 1, 0, 1, A, 0, 0, 0, 0, 0, 0);
    lr("R5 LR ctx3 same granule", 3, A);
    sc("R5 SC ctx0 still passes", 0, A);
    sc("R8 SC ctx3 lost to ctx0 store", 3, A);

    pw("R6 plain write without reservation", 1, B);
    idle("R9 quiet after write");

    lr("R7 LR ctx1", 1, A);
    sc("R7 SC ctx2 with foreign reservation fails", 2, A);
    sc("R8 failed SC invalidated ctx1", 1, A);

    lr("R8 LR ctx0", 0, B);
    lr("R8 LR ctx3", 3, B + 1);
    pw("R6 plain write kills both", 2, B + 8);
    sc("R8 ctx0 invalidated", 0, B);
    sc("R8 ctx3 invalidated", 3, B);

    lr("R10 LR ctx2", 2, A);
    step("R10 clear ctx2", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2);
    sc("R10 SC ctx2 after clear fails", 2, A);
    lr("R10 LR ctx1", 1, A);
    step("R10 clear ctx3 only", 0, 0, 0, 0, 0, 0, 0, 0, 1, 3);
    sc("R10 SC ctx1 survives other clear", 1, A);

    step("R11 LR ctx0 with plain write same granule", 1, 1, 0, A, 1, 0, 1, A + 8, 0, 0);
    sc("R11 reservation recorded after write", 0, A);
    lr("R11 LR ctx1", 1, B);
    step("R11 SC ctx1 with LR ctx1 same edge", 1, 1, 1, B, 1, 1, 1, B, 0, 0);
    sc("R11 new reservation kept", 1, B);
    step("R11 clear with LR same ctx", 1, 1, 2, A, 0, 0, 0, 0, 1, 2);
    sc("R11 reservation kept over clear", 2, A);

    // Mixed traffic against the model.
    for (int n = 0; n < 400; n++) begin
      int unsigned addrs [5];
      addrs[0] = A; addrs[1] = A + 4; addrs[2] = B; addrs[3] = B + 8; addrs[4] = 32'h300;
      step("R8 mixed traffic",
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 3)),
           addrs[$urandom_range(0, 4)],
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 3)),
           addrs[$urandom_range(0, 4)],
           1'($urandom_range(0, 9) == 0), int'($urandom_range(0, 3)));
    end

    rst_n = 1'b0;
    for (int i = 0; i < NC; i++) mv[i] = 0;
    @(negedge clk);
    compare("R1 reset again", {rd_ready || wr_ready, mem_we, sc_valid, sc_result}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    sc("R1 reservations gone after reset", 2, A);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule